// File: doc/BRIEF.md
# Doubleword Shift Execution Unit

This unit is the shift pipe of a 64-bit integer core. It shifts a 64-bit source left or right. A logical shift fills the vacated positions with zeros. An arithmetic right shift fills them with copies of the sign bit. The amount comes either from a register operand or from an immediate. The immediate arrives as two separate fields, one bit high and five bits low, and the unit joins them into a 6-bit amount. Two further operations work on the low 32-bit word of the source:

- a 32-bit arithmetic right shift by register;
- a sign-extend of that word to 64 bits, followed by a left shift by the immediate.

Each accepted request returns its result one clock later, marked by a valid strobe. The arithmetic right shifts also report a carry. That carry is set only when a negative value loses at least one set bit. When the request carries the record bit, the unit also produces a 4-bit condition field from the signed 64-bit result. The issue stage owns the carry and condition registers. It writes them only when the matching write-enable strobe is high.

Top module: `dwshift_unit`

## Requirements
- R1: Operation code 0 shifts left logically and code 1 shifts right logically. The amount is bit 6 and bits 5:0 of the amount operand. If bit 6 is set the result is zero. Otherwise the source is shifted by bits 5:0 and the vacated positions are filled with zeros.
- R2: For code 2 (arithmetic right by register), when bit 6 of the amount operand is set, the result is 64 copies of source bit 63, and the carry equals source bit 63.
- R3: For code 2 with bit 6 clear, the source is shifted right by bits 5:0 with sign fill. The carry is 1 exactly when the source is negative and at least one 1 bit was shifted out.
- R4: For every arithmetic right shift (codes 2, 3 and 4), a zero amount returns the operand unshifted and clears the carry. For code 4 the operand is the sign-extended low word.
- R5: The immediate amount is {imm_hi, imm_lo}, with imm_hi as bit 5. Code 3 shifts right arithmetically by that amount, using the carry rule of R3.
- R6: Code 5 sign-extends source bits 31:0 to 64 bits and shifts the result left by the immediate amount. It never asserts the carry write enable.
- R7: Code 4 sign-extends source bits 31:0. If bit 5 of the amount operand is set, the result is all copies of source bit 31 and the carry equals that bit. Otherwise the operand is shifted right by bits 4:0 with sign fill, and the carry is 1 when the word is negative and a 1 bit was shifted out.
- R8: When the record bit is set on a defined operation, the condition write enable is asserted. The condition field has bit 3 = result negative, bit 2 = result positive, bit 1 = result zero, and bit 0 = the incoming summary-overflow flag.
- R9: The carry write enable is asserted only for codes 2, 3 and 4.
- R10: The result and its strobes appear exactly one clock after a request with valid high. Without a request, the valid and both write enables are low. A synchronous active-high reset clears every output.
- R11: Codes 6 and 7 give a zero result with both write enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 3 | Operation code |
| in_src | input | 64 | Source operand |
| in_amt | input | 64 | Register shift-amount operand |
| in_imm_hi | input | 1 | High bit of the immediate amount |
| in_imm_lo | input | 5 | Low five bits of the immediate amount |
| in_rec | input | 1 | Record bit: request a condition-field write |
| in_so | input | 1 | Current summary-overflow flag |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Shift result |
| out_ca | output | 1 | Carry value |
| out_ca_we | output | 1 | Carry write enable |
| out_cr | output | 4 | Condition field {neg, pos, zero, so} |
| out_cr_we | output | 1 | Condition write enable |

## Verification
The random stimulus mixes two kinds of shift amount.

- Small amounts below 128 reach every in-range shift and the bit-6 saturation.
- Full 64-bit amounts check that the upper operand bits are ignored.

Random sources are paired with directed ones:

- negative words whose shifted-out bits are all zero, which separates "negative" from "negative and lost a set bit" in the carry;
- zero amounts, which separate the unshifted path from a shift by 64;
- split immediates with only the high field set, which show whether the two fields are joined in the right order.

Zero, positive and negative results with the record bit set tell the three relation bits apart.

// File: rtl/dwshift_pkg.sv
package dwshift_pkg;

  typedef enum logic [2:0] {
    OP_SHL     = 3'd0,
    OP_SHR     = 3'd1,
    OP_SRA_R   = 3'd2,
    OP_SRA_I   = 3'd3,
    OP_SRA_W   = 3'd4,
    OP_EXTS_SL = 3'd5
  } shop_e;

  function automatic logic is_arith(input logic [2:0] op);
    return (op == OP_SRA_R) || (op == OP_SRA_I) || (op == OP_SRA_W);
  endfunction

  function automatic logic is_known(input logic [2:0] op);
    return op <= 3'd5;
  endfunction

endpackage

// File: rtl/dwshift_core.sv
module dwshift_core
  import dwshift_pkg::*;
#(
  parameter int DW = 64,
  localparam int SHW = $clog2(DW),
  localparam int HW = DW / 2
) (
  input  logic [2:0]     op,
  input  logic [DW-1:0]  src,
  input  logic [SHW:0]   amt,
  input  logic [SHW-1:0] imm_amt,
  output logic [DW-1:0]  res,
  output logic           ca,
  output logic           ca_we,
  output logic           op_known
);

  function automatic logic [DW-1:0] sra_f(input logic [DW-1:0] v, input logic [SHW-1:0] s);
    return DW'($signed(v) >>> s);
  endfunction

  function automatic logic lost_f(input logic [DW-1:0] v, input logic [SHW-1:0] s);
    logic [DW-1:0] keep_mask;
    keep_mask = ~({DW{1'b1}} << s);
    return |(v & keep_mask);
  endfunction

  wire            sat_dw   = amt[SHW];
  wire [SHW-1:0]  sh_dw    = amt[SHW-1:0];
  wire            sat_w    = amt[SHW-1];
  wire [SHW-1:0]  sh_w     = {1'b0, amt[SHW-2:0]};
  wire            sign_dw  = src[DW-1];
  wire            sign_w   = src[HW-1];
  wire [DW-1:0]   sx_word  = {{HW{src[HW-1]}}, src[HW-1:0]};

  always_comb begin
    res      = '0;
    ca       = 1'b0;
    ca_we    = 1'b0;
    op_known = 1'b1;
    case (op)
      OP_SHL: res = sat_dw ? '0 : (src << sh_dw);
      OP_SHR: res = sat_dw ? '0 : (src >> sh_dw);
      OP_SRA_R: begin
        ca_we = 1'b1;
        if (sat_dw) begin
          res = {DW{sign_dw}};
          ca  = sign_dw;
        end else begin
          res = sra_f(src, sh_dw);
          ca  = sign_dw & lost_f(src, sh_dw);
        end
      end
      OP_SRA_I: begin
        ca_we = 1'b1;
        res   = sra_f(src, imm_amt);
        ca    = sign_dw & lost_f(src, imm_amt);
      end
      OP_SRA_W: begin
        ca_we = 1'b1;
        if (sat_w) begin
          res = {DW{sign_w}};
          ca  = sign_w;
        end else begin
          res = sra_f(sx_word, sh_w);
          ca  = sign_w & lost_f(sx_word, sh_w);
        end
      end
      OP_EXTS_SL: res = sx_word << imm_amt;
      default: op_known = 1'b0;
    endcase
  end

  always_comb begin
    if (op == OP_SRA_R && !sat_dw && sh_dw == '0)
      AST_SRA_ZERO_AMT: assert (res == src && !ca); // R4
    if (op == OP_SRA_R && sat_dw)
      AST_SRA_SAT_SIGN: assert (ca == src[DW-1] && res[0] == src[DW-1]); // R2
  end

endmodule

// File: rtl/dwshift_cond.sv
module dwshift_cond #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] res,
  input  logic          so,
  output logic [3:0]    cr
);

  wire is_neg  = res[DW-1];
  wire is_zero = (res == '0);
  wire is_pos  = !is_neg && !is_zero;

  assign cr = {is_neg, is_pos, is_zero, so};

endmodule

// File: rtl/dwshift_unit.sv
module dwshift_unit
  import dwshift_pkg::*;
#(
  parameter int DW = 64,
  localparam int SHW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [2:0]     in_op,
  input  logic [DW-1:0]  in_src,
  input  logic [DW-1:0]  in_amt,
  input  logic           in_imm_hi,
  input  logic [SHW-2:0] in_imm_lo,
  input  logic           in_rec,
  input  logic           in_so,
  output logic           out_valid,
  output logic [DW-1:0]  out_result,
  output logic           out_ca,
  output logic           out_ca_we,
  output logic [3:0]     out_cr,
  output logic           out_cr_we
);

  logic [DW-1:0]  core_res;
  logic           core_ca;
  logic           core_ca_we;
  logic           core_known;
  logic [3:0]     core_cr;
  logic           unused_amt_hi;

  wire [SHW-1:0]  imm_amt   = {in_imm_hi, in_imm_lo};
  wire            accept    = in_valid;
  wire            want_cr   = accept && in_rec && core_known;
  wire            want_ca   = accept && core_ca_we;

  assign unused_amt_hi = ^in_amt[DW-1:SHW+1];

  dwshift_core #(.DW(DW)) u_core (
    .op       (in_op),
    .src      (in_src),
    .amt      (in_amt[SHW:0]),
    .imm_amt  (imm_amt),
    .res      (core_res),
    .ca       (core_ca),
    .ca_we    (core_ca_we),
    .op_known (core_known)
  );

  dwshift_cond #(.DW(DW)) u_cond (
    .res (core_res),
    .so  (in_so),
    .cr  (core_cr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ca     <= 1'b0;
      out_ca_we  <= 1'b0;
      out_cr     <= '0;
      out_cr_we  <= 1'b0;
    end else begin
      out_valid <= accept;
      out_ca_we <= want_ca;
      out_cr_we <= want_cr;
      if (accept) begin
        out_result <= core_res;
        out_ca     <= core_ca;
        out_cr     <= core_cr;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid))); // R10
  AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (out_ca_we || out_cr_we) |-> out_valid); // R10
  AST_CA_WE_ARITH: assert property (@(posedge clk) disable iff (rst)
    out_ca_we |-> is_arith($past(in_op))); // R9
  AST_LSH_SAT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == OP_SHL || in_op == OP_SHR) && in_amt[SHW]) |=> (out_result == '0)); // R1
  AST_EXTS_NO_CA: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_EXTS_SL) |=> !out_ca_we); // R6
  AST_CR_ONE_REL: assert property (@(posedge clk) disable iff (rst)
    out_cr_we |-> $onehot(out_cr[3:1])); // R8
  AST_UNUSED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_known(in_op)) |=> (out_result == '0 && !out_ca_we && !out_cr_we)); // R11

endmodule

// File: tb/dwshift_unit_tb.sv
module dwshift_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = '0;
  logic [63:0] in_src = '0;
  logic [63:0] in_amt = '0;
  logic        in_imm_hi = 1'b0;
  logic [4:0]  in_imm_lo = '0;
  logic        in_rec = 1'b0;
  logic        in_so = 1'b0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_ca;
  logic        out_ca_we;
  logic [3:0]  out_cr;
  logic        out_cr_we;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwshift_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_src(in_src),
    .in_amt(in_amt), .in_imm_hi(in_imm_hi), .in_imm_lo(in_imm_lo), .in_rec(in_rec),
    .in_so(in_so), .out_valid(out_valid), .out_result(out_result), .out_ca(out_ca),
    .out_ca_we(out_ca_we), .out_cr(out_cr), .out_cr_we(out_cr_we)
  );

  // Model: arithmetic shift through a 128-bit window
  function automatic logic [63:0] m_sra(input logic [63:0] v, input int s);
    logic [127:0] w;
    w = {{64{v[63]}}, v};
    w = w >> s;
    return w[63:0];
  endfunction

  // Model: any set bit among the low s bits
  function automatic logic m_lost(input logic [63:0] v, input int s);
    logic [63:0] t;
    if (s == 0) return 1'b0;
    t = v << (64 - s);
    return t != 64'd0;
  endfunction

  logic [63:0] e_res;
  logic        e_ca, e_ca_we, e_cr_we;
  logic [3:0]  e_cr;
  string       e_tag;

  task automatic model(input logic [2:0] op, input logic [63:0] src, input logic [63:0] amt,
                       input logic hi, input logic [4:0] lo, input logic rec, input logic so);
    int imm;
    logic [63:0] sx;
    imm = {26'd0, hi, lo};
    sx = {{32{src[31]}}, src[31:0]};
    e_ca = 1'b0; e_ca_we = 1'b0; e_res = '0; e_cr_we = rec;
    case (op)
      3'd0: begin e_tag = "R1"; e_res = amt[6] ? 64'd0 : src << amt[5:0]; end
      3'd1: begin e_tag = "R1"; e_res = amt[6] ? 64'd0 : src >> amt[5:0]; end
      3'd2: begin
        e_ca_we = 1'b1;
        if (amt[6]) begin e_tag = "R2"; e_res = {64{src[63]}}; e_ca = src[63]; end
        else begin
          e_tag = (amt[5:0] == 0) ? "R4" : "R3";
          e_res = m_sra(src, int'(amt[5:0]));
          e_ca = src[63] && m_lost(src, int'(amt[5:0]));
        end
      end
      3'd3: begin
        e_tag = (imm == 0) ? "R4" : "R5"; e_ca_we = 1'b1;
        e_res = m_sra(src, imm); e_ca = src[63] && m_lost(src, imm);
      end
      3'd4: begin
        e_tag = "R7"; e_ca_we = 1'b1;
        if (amt[5]) begin e_res = {64{src[31]}}; e_ca = src[31]; end
        else begin
          if (amt[4:0] == 0) e_tag = "R4";
          e_res = m_sra(sx, int'(amt[4:0]));
          e_ca = src[31] && m_lost(sx, int'(amt[4:0]));
        end
      end
      3'd5: begin e_tag = "R6"; e_res = sx << imm; end
      default: begin e_tag = "R11"; e_cr_we = 1'b0; end
    endcase
    e_cr = {$signed(e_res) < 0, $signed(e_res) > 0, e_res == 64'd0, so};
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, check at the following falling edge
  task automatic run_op(input logic [2:0] op, input logic [63:0] src, input logic [63:0] amt,
                        input logic hi, input logic [4:0] lo, input logic rec, input logic so);
    in_valid = 1'b1; in_op = op; in_src = src; in_amt = amt;
    in_imm_hi = hi; in_imm_lo = lo; in_rec = rec; in_so = so;
    model(op, src, amt, hi, lo, rec, so);
    @(negedge clk);
    chk("R10 valid", {63'd0, out_valid}, 64'd1);
    chk({e_tag, " result"}, out_result, e_res);
    chk("R9 ca_we", {63'd0, out_ca_we}, {63'd0, e_ca_we});
    if (e_ca_we) chk({e_tag, " carry"}, {63'd0, out_ca}, {63'd0, e_ca});
    chk("R8 cr_we", {63'd0, out_cr_we}, {63'd0, e_cr_we});
    if (e_cr_we) chk("R8 cr", {60'd0, out_cr}, {60'd0, e_cr});
  endtask

  task automatic idle_check();
    in_valid = 1'b0;
    in_op = 3'd2;
    in_rec = 1'b1;
    @(negedge clk);
    chk("R10 idle valid", {63'd0, out_valid}, 64'd0);
    chk("R10 idle ca_we", {63'd0, out_ca_we}, 64'd0);
    chk("R10 idle cr_we", {63'd0, out_cr_we}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20210206));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R10 reset result", out_result, 64'd0);
    chk("R10 reset ca_we", {63'd0, out_ca_we}, 64'd0);
    chk("R10 reset cr_we", {63'd0, out_cr_we}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // Directed corner cases
    run_op(3'd0, 64'hFFFF_0000_1234_5678, 64'd64, 0, 0, 1, 0);               // R1 saturate
    run_op(3'd1, 64'h8000_0000_0000_0000, 64'd63, 0, 0, 1, 1);               // R1
    run_op(3'd0, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FF85, 0, 0, 1, 0); // R1 high bits ignored
    run_op(3'd2, 64'h8000_0000_0000_0000, 64'd64, 0, 0, 1, 0);               // R2 negative
    run_op(3'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'd127, 0, 0, 1, 0);              // R2 positive
    run_op(3'd2, 64'h8000_0000_0000_0000, 64'd4, 0, 0, 1, 0);                // R3 no lost ones
    run_op(3'd2, 64'h8000_0000_0000_0008, 64'd4, 0, 0, 1, 0);                // R3 lost one
    run_op(3'd2, 64'h7000_0000_0000_00FF, 64'd4, 0, 0, 1, 0);                // R3 positive, no carry
    run_op(3'd2, 64'hF000_0000_0000_00FF, 64'd0, 0, 0, 1, 0);                // R4 register
    run_op(3'd3, 64'hF000_0000_0000_00FF, 64'd0, 0, 0, 1, 0);                // R4 immediate
    run_op(3'd4, 64'h0000_0000_8000_0001, 64'd0, 0, 0, 1, 0);                // R4 word
    run_op(3'd3, 64'h8000_0001_0000_0000, 64'd0, 1, 0, 1, 0);                // R5 amount 32
    run_op(3'd3, 64'h8000_0000_0000_0001, 64'd0, 1, 5'd31, 1, 0);            // R5 amount 63
    run_op(3'd5, 64'h1234_5678_8000_0001, 64'd0, 0, 0, 1, 0);                // R6 no shift
    run_op(3'd5, 64'h0000_0000_0000_0003, 64'd0, 1, 5'd30, 1, 0);            // R6 amount 62
    run_op(3'd4, 64'h0000_0000_8000_0000, 64'd32, 0, 0, 1, 0);               // R7 saturate
    run_op(3'd4, 64'hFFFF_FFFF_7FFF_FFFF, 64'd8, 0, 0, 1, 0);                // R7 upper ignored
    run_op(3'd4, 64'h0000_0000_8000_0100, 64'd8, 0, 0, 0, 0);                // R7 no lost ones
    run_op(3'd1, 64'd5, 64'd3, 0, 0, 1, 1);                                  // R8 zero result, so
    run_op(3'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1, 5'd1, 1, 1);             // R11
    run_op(3'd7, 64'h1, 64'd0, 0, 0, 1, 0);                                  // R11
    idle_check();                                                            // R10

    // Random stimulus
    for (int i = 0; i < 600; i++) begin
      logic [2:0]  op;
      logic [63:0] src, amt;
      op  = 3'($urandom % 8);
      src = {$urandom, $urandom};
      if ($urandom % 4 == 0) src = src >> ($urandom % 64);
      amt = ($urandom % 3 == 0) ? {$urandom, $urandom} : 64'($urandom % 128);
      run_op(op, src, amt, 1'($urandom), 5'($urandom), 1'($urandom), 1'($urandom));
      if (i % 50 == 0) idle_check();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule